// File: doc/BRIEF.md
# Signed Arithmetic Shifter with Register-Pair Mode

This block shifts a signed value by a 6-bit two's-complement count. A count with its top bit clear shifts left by the count. A count with its top bit set shifts right by 64 minus the count. The shift applies to one of two operands. The first is a single 16-bit register. The second is a 32-bit value built from an even/odd register pair, with the high half taken from the named register and the low half from its neighbour. The block reports the shifted data together with the negative, zero, overflow and carry flags.

A request is presented for one cycle on `start`. The operand words, the count, the low bit of the register number and the pair select are sampled on that edge. One cycle later the results and the flags appear on registered outputs, and `done` pulses for exactly one cycle. The outputs keep their values until the next request.

When pair mode names an odd register, a right shift becomes a rotation of that single register by the right-shift amount modulo 16. A left shift or a zero count in that case falls back to the plain 16-bit shift.

Top module: `sashift_top`

## Requirements
- R1: Count bit 5 clear selects a left shift by the count (0..31). Count bit 5 set selects an arithmetic right shift by 64 minus the count (1..32).
- R2: A zero count returns the operand unchanged with C=0 and V=0, in every mode.
- R3: In word mode, a left shift by 1..15 fills with zeros from bit 0. C is the last bit to leave bit 15, which is original bit 16-k. V is 1 when bit 15 changed at any step, meaning the top k+1 original bits are not all equal.
- R4: In word mode, a left shift by 16..31 gives zero. C equals original bit 0 only when the shift is exactly 16, and is 0 otherwise. V is 1 exactly when the original value was nonzero.
- R5: In word mode, a right shift by 1..15 fills with copies of bit 15, and C is the last bit shifted out (original bit k-1). A right shift by 16 or more gives all copies of the sign, with C equal to the sign. Every right shift leaves V=0.
- R6: Pair mode with register-number bit 0 equal to 0 shifts the 32-bit value {hi_in, lo_in}. The result goes to {hi_out, lo_out}. The R3/R5 rules apply at width 32, and right shifts reach 32 positions.
- R7: Pair mode with register-number bit 0 equal to 1 and count bit 5 set rotates hi_in right by (64 minus count) mod 16. In this case C=0 and V=0.
- R8: Pair mode with an odd register and count bit 5 clear behaves exactly as word mode.
- R9: N equals bit 15 of hi_out. Z is 1 when the result is zero, tested over 32 bits in even pair mode and over hi_out alone otherwise.
- R10: lo_out equals the sampled lo_in in every mode except even pair mode.
- R11: Results and flags appear on the cycle after `start`, and `done` is high on that cycle only. The outputs hold while `start` stays low.
- R12: Synchronous reset clears all outputs and holds `done` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe; inputs are sampled on this edge |
| pair_mode | input | 1 | 1 selects register-pair operation |
| reg_lsb | input | 1 | Bit 0 of the register number (0 = even, 1 = odd) |
| count | input | 6 | Two's-complement shift count |
| hi_in | input | 16 | Named register (high half in even pair mode) |
| lo_in | input | 16 | Neighbour register (low half in even pair mode) |
| done | output | 1 | One-cycle result strobe |
| hi_out | output | 16 | Shifted named register |
| lo_out | output | 16 | Shifted low half, or lo_in passed through |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag (sign changed during a left shift) |
| flag_c | output | 1 | Carry flag (last bit shifted out) |

## Verification
All 64 count codes are run through word mode, even pair mode and odd pair mode. This checks that the left/right decode and the shift amount agree at the edges: 0, 15, 16, 31, 32 and 63. Directed operands separate the last-bit-out carry from the sign, and a sign change at an early step from one at the last step. Dedicated values confirm that an exact 16-position left shift alone keeps bit 0 in C, that a 32-position pair right shift fills with the sign, and that rotate amounts of 16 and 32 collapse to no rotation. A pseudo-random mix of modes and operands checks the zero test and the pass-through of the neighbour register in every mode.

// File: rtl/sash_pkg.sv
package sash_pkg;

    localparam int SASH_WORD_W = 16;
    localparam int SASH_CNT_W  = 6;

    typedef enum logic [1:0] {
        DIR_NONE  = 2'd0,
        DIR_LEFT  = 2'd1,
        DIR_RIGHT = 2'd2
    } dir_e;

    typedef enum logic [1:0] {
        SM_WORD = 2'd0,
        SM_PAIR = 2'd1,
        SM_ROT  = 2'd2
    } shift_mode_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [SASH_WORD_W-1:0] hi;
        logic [SASH_WORD_W-1:0] lo;
        flags_t                 f;
    } result_t;

    // Pick the operating variant from the pair select, register parity and direction.
    function automatic shift_mode_e pick_mode(input logic pair, input logic odd, input dir_e dir);
        if (pair && !odd)
            return SM_PAIR;
        else if (pair && odd && dir == DIR_RIGHT)
            return SM_ROT;
        else
            return SM_WORD;
    endfunction

endpackage

// File: rtl/sash_cnt_dec.sv
module sash_cnt_dec
    import sash_pkg::*;
#(
    parameter int CNT_W = SASH_CNT_W
) (
    input  logic [CNT_W-1:0] count,
    output dir_e             dir,
    output logic [CNT_W-1:0] mag
);
    always_comb begin
        if (count == '0) begin
            dir = DIR_NONE;
            mag = '0;
        end else if (count[CNT_W-1]) begin
            dir = DIR_RIGHT;
            mag = CNT_W'(-count);   // 2^CNT_W minus count
        end else begin
            dir = DIR_LEFT;
            mag = count;
        end
    end

    // R1: a right shift always has a nonzero magnitude
    always_comb begin
        if (dir == DIR_RIGHT) assert (mag != '0);
    end
endmodule

// File: rtl/sash_shift_core.sv
module sash_shift_core
    import sash_pkg::*;
#(
    parameter int W     = SASH_WORD_W,
    parameter int AMT_W = SASH_CNT_W
) (
    input  logic [W-1:0]     x,
    input  dir_e             dir,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     y,
    output logic             c,
    output logic             v
);
    localparam logic [W-1:0] ALL1 = '1;

    logic [W-1:0] top_mask;
    logic [W-1:0] top_bits;
    logic [W-1:0] out_shift;
    int           k;

    always_comb begin
        k         = int'(amt);
        y         = x;
        c         = 1'b0;
        v         = 1'b0;
        top_mask  = '0;
        top_bits  = '0;
        out_shift = '0;
        unique case (dir)
            DIR_LEFT: begin
                if (k < W) begin
                    y         = x << amt;
                    out_shift = x >> (W - k);
                    c         = out_shift[0];
                    top_mask  = ~(ALL1 >> (k + 1));
                    top_bits  = x & top_mask;
                    v         = (top_bits != '0) && (top_bits != top_mask);
                end else begin
                    y = '0;
                    c = (k == W) ? x[0] : 1'b0;
                    v = (x != '0);
                end
            end
            DIR_RIGHT: begin
                if (k >= W) begin
                    y = {W{x[W-1]}};
                    c = x[W-1];
                end else begin
                    y         = W'($signed(x) >>> amt);
                    out_shift = x >> (k - 1);
                    c         = out_shift[0];
                end
            end
            default: begin
                y = x;
            end
        endcase
    end

    // R5: right shifts never report overflow
    always_comb begin
        if (dir == DIR_RIGHT) assert (!v);
    end
endmodule

// File: rtl/sash_rot_unit.sv
module sash_rot_unit
    import sash_pkg::*;
#(
    parameter int W    = SASH_WORD_W,
    parameter int RA_W = $clog2(W)
) (
    input  logic [W-1:0]    x,
    input  logic [RA_W-1:0] amt,
    output logic [W-1:0]    y
);
    always_comb begin
        y = W'({x, x} >> amt);
    end

    // R7: a rotation preserves the population count
    always_comb begin
        assert ($countones(y) == $countones(x));
    end
endmodule

// File: rtl/sashift_top.sv
module sashift_top
    import sash_pkg::*;
#(
    parameter int WORD_W = SASH_WORD_W,
    parameter int CNT_W  = SASH_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              pair_mode,
    input  logic              reg_lsb,
    input  logic [CNT_W-1:0]  count,
    input  logic [WORD_W-1:0] hi_in,
    input  logic [WORD_W-1:0] lo_in,
    output logic              done,
    output logic [WORD_W-1:0] hi_out,
    output logic [WORD_W-1:0] lo_out,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    localparam int PAIR_W = 2 * WORD_W;
    localparam int ROT_W  = $clog2(WORD_W);

    dir_e               dir;
    logic [CNT_W-1:0]   mag;
    shift_mode_e        mode;

    logic [WORD_W-1:0]  w_y;
    logic               w_c, w_v;
    logic [PAIR_W-1:0]  p_y;
    logic               p_c, p_v;
    logic [WORD_W-1:0]  r_y;

    result_t            nxt;
    result_t            res_q;
    logic               done_q;

    sash_cnt_dec #(.CNT_W(CNT_W)) u_dec (
        .count (count),
        .dir   (dir),
        .mag   (mag)
    );

    sash_shift_core #(.W(WORD_W), .AMT_W(CNT_W)) u_word (
        .x   (hi_in),
        .dir (dir),
        .amt (mag),
        .y   (w_y),
        .c   (w_c),
        .v   (w_v)
    );

    sash_shift_core #(.W(PAIR_W), .AMT_W(CNT_W)) u_pair (
        .x   ({hi_in, lo_in}),
        .dir (dir),
        .amt (mag),
        .y   (p_y),
        .c   (p_c),
        .v   (p_v)
    );

    sash_rot_unit #(.W(WORD_W), .RA_W(ROT_W)) u_rot (
        .x   (hi_in),
        .amt (mag[ROT_W-1:0]),
        .y   (r_y)
    );

    always_comb begin
        mode = pick_mode(pair_mode, reg_lsb, dir);
        nxt  = '0;
        unique case (mode)
            SM_PAIR: begin
                nxt.hi  = p_y[PAIR_W-1:WORD_W];
                nxt.lo  = p_y[WORD_W-1:0];
                nxt.f.z = (p_y == '0);
                nxt.f.v = p_v;
                nxt.f.c = p_c;
            end
            SM_ROT: begin
                nxt.hi  = r_y;
                nxt.lo  = lo_in;
                nxt.f.z = (r_y == '0);
                nxt.f.v = 1'b0;
                nxt.f.c = 1'b0;
            end
            default: begin
                nxt.hi  = w_y;
                nxt.lo  = lo_in;
                nxt.f.z = (w_y == '0);
                nxt.f.v = w_v;
                nxt.f.c = w_c;
            end
        endcase
        nxt.f.n = nxt.hi[WORD_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start;
            if (start) res_q <= nxt;
        end
    end

    assign done   = done_q;
    assign hi_out = res_q.hi;
    assign lo_out = res_q.lo;
    assign flag_n = res_q.f.n;
    assign flag_z = res_q.f.z;
    assign flag_v = res_q.f.v;
    assign flag_c = res_q.f.c;

    p_done_after_start_r11: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done && $stable(hi_out) && $stable(lo_out));

    p_zero_count_r2: assert property (@(posedge clk) disable iff (rst)
        (start && count == '0) |=> (!flag_c && !flag_v && hi_out == $past(hi_in)));

    p_right_no_v_r5: assert property (@(posedge clk) disable iff (rst)
        (start && count[CNT_W-1]) |=> !flag_v);

    p_n_is_sign_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_n == hi_out[WORD_W-1]));

    p_lo_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !(pair_mode && !reg_lsb)) |=> (lo_out == $past(lo_in)));

endmodule

// File: tb/sashift_top_tb.sv
`timescale 1ns/1ps
module sashift_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        pair_mode = 1'b0;
    logic        reg_lsb = 1'b0;
    logic [5:0]  count = '0;
    logic [15:0] hi_in = '0;
    logic [15:0] lo_in = '0;
    logic        done;
    logic [15:0] hi_out, lo_out;
    logic        flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] hi;
        logic [15:0] lo;
        logic        n, z, v, c;
        string       tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    sashift_top u_dut (
        .clk(clk), .rst(rst), .start(start), .pair_mode(pair_mode),
        .reg_lsb(reg_lsb), .count(count), .hi_in(hi_in), .lo_in(lo_in),
        .done(done), .hi_out(hi_out), .lo_out(lo_out),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    // Step-by-step reference written from the requirements.
    function automatic item_t model(logic pm, logic odd, logic [5:0] cnt,
                                    logic [15:0] h, logic [15:0] l, string tag);
        item_t r;
        logic [31:0] x;
        logic sgn;
        int w, k;
        r.tag = tag; r.lo = l; r.v = 1'b0; r.c = 1'b0;
        if (pm && odd && cnt[5]) begin
            k = (64 - int'(cnt)) % 16;
            x = {16'h0, h};
            for (int i = 0; i < k; i++) x[15:0] = {x[0], x[15:1]};
            r.hi = x[15:0];
            r.z = (x[15:0] == 16'h0);
            r.n = r.hi[15];
            return r;
        end
        w = (pm && !odd) ? 32 : 16;
        x = (w == 32) ? {h, l} : {16'h0, h};
        if (cnt == 6'd0) begin
            r.c = 1'b0;
        end else if (!cnt[5]) begin
            for (int i = 0; i < int'(cnt); i++) begin
                r.c = x[w-1];
                if (x[w-1] != x[w-2]) r.v = 1'b1;
                x = x << 1;
                if (w == 16) x[31:16] = 16'h0;
            end
        end else begin
            k = 64 - int'(cnt);
            for (int i = 0; i < k; i++) begin
                r.c = x[0];
                sgn = x[w-1];
                x = x >> 1;
                x[w-1] = sgn;
            end
        end
        if (w == 32) begin
            r.hi = x[31:16]; r.lo = x[15:0]; r.z = (x == 32'h0);
        end else begin
            r.hi = x[15:0]; r.z = (x[15:0] == 16'h0);
        end
        r.n = r.hi[15];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: one request per negedge, expected item pushed to the scoreboard.
    task automatic run(input logic pm, input logic odd, input logic [5:0] cnt,
                       input logic [15:0] h, input logic [15:0] l, input string tag);
        @(negedge clk);
        pair_mode = pm; reg_lsb = odd; count = cnt; hi_in = h; lo_in = l;
        start = 1'b1;
        sb.push_back(model(pm, odd, cnt, h, l, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: compare each result as the strobe appears.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11", "unexpected done", 40'd1, 40'd0);
            end else begin
                item_t e;
                e = sb.pop_front();
                check({hi_out, lo_out, flag_n, flag_z, flag_v, flag_c} ==
                      {e.hi, e.lo, e.n, e.z, e.v, e.c}, e.tag, "result{hi,lo,nzvc}",
                      {4'h0, hi_out, lo_out, flag_n, flag_z, flag_v, flag_c},
                      {4'h0, e.hi, e.lo, e.n, e.z, e.v, e.c});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        logic [15:0] hold_hi;
        repeat (3) @(negedge clk);
        // R12: reset state
        check({done, hi_out, lo_out, flag_n, flag_z, flag_v, flag_c} == '0, "R12", "reset outputs",
              {3'h0, done, hi_out, lo_out, flag_n, flag_z, flag_v, flag_c}, 40'd0);
        rst = 1'b0;

        // R1: decode of left and right counts
        run(0, 0, 6'd3,  16'h0011, 16'h0000, "R1");
        run(0, 0, 6'd63, 16'h8003, 16'h0000, "R1");
        // R2: zero count in each mode
        run(0, 0, 6'd0,  16'h8000, 16'h1234, "R2");
        run(1, 0, 6'd0,  16'hFFFF, 16'h0001, "R2");
        run(1, 1, 6'd0,  16'hC001, 16'h5555, "R2");
        // R3: word left 1..15
        run(0, 0, 6'd1,  16'h4000, 16'h0000, "R3");
        run(0, 0, 6'd15, 16'h0001, 16'h0000, "R3");
        run(0, 0, 6'd4,  16'hF123, 16'h0000, "R3");
        run(0, 0, 6'd2,  16'hE000, 16'h0000, "R3");
        // R4: word left 16..31
        run(0, 0, 6'd16, 16'h0001, 16'h0000, "R4");
        run(0, 0, 6'd17, 16'h0001, 16'h0000, "R4");
        run(0, 0, 6'd20, 16'h0000, 16'h0000, "R4");
        run(0, 0, 6'd16, 16'h0002, 16'h0000, "R4");
        run(0, 0, 6'd31, 16'hFFFF, 16'h0000, "R4");
        // R5: word right, including beyond 15
        run(0, 0, 6'd48, 16'h8000, 16'h0000, "R5");
        run(0, 0, 6'd32, 16'h7FFF, 16'h0000, "R5");
        run(0, 0, 6'd60, 16'h8010, 16'h0000, "R5");
        run(0, 0, 6'd59, 16'h8010, 16'h0000, "R5");
        run(0, 0, 6'd49, 16'hC000, 16'h0000, "R5");
        // R6: even pair
        run(1, 0, 6'd8,  16'h0012, 16'h3456, "R6");
        run(1, 0, 6'd32, 16'h8000, 16'h0001, "R6");
        run(1, 0, 6'd63, 16'h0000, 16'h0001, "R6");
        run(1, 0, 6'd31, 16'h0000, 16'h0001, "R6");
        run(1, 0, 6'd33, 16'h4000, 16'h0000, "R6");
        // R7: odd pair rotate
        run(1, 1, 6'd60, 16'h1234, 16'hAAAA, "R7");
        run(1, 1, 6'd48, 16'h1234, 16'hAAAA, "R7");
        run(1, 1, 6'd32, 16'h8001, 16'hAAAA, "R7");
        run(1, 1, 6'd63, 16'h0001, 16'hAAAA, "R7");
        // R8: odd pair left falls back to word shift
        run(1, 1, 6'd2,  16'hC000, 16'h7777, "R8");
        run(1, 1, 6'd16, 16'h0003, 16'h7777, "R8");
        // R10: neighbour register passes through
        run(0, 0, 6'd5,  16'h00F0, 16'hBEEF, "R10");
        run(1, 1, 6'd61, 16'h00F0, 16'hBEEF, "R10");

        // R1 / R6 / R7 sweeps across every count code
        for (int i = 0; i < 64; i++) run(0, 0, 6'(i), 16'h9A5C, 16'h0F0F, "R1");
        for (int i = 0; i < 64; i++) run(1, 0, 6'(i), 16'hC3A5, 16'h5A01, "R6");
        for (int i = 0; i < 64; i++) run(1, 1, 6'(i), 16'h8421, 16'h1357, "R7");

        // R9: pseudo-random mix, zero and sign flags in all modes
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 80; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run(lfsr[3], lfsr[7], lfsr[13:8],
                (lfsr[4:2] == 3'd0) ? 16'h0000 : lfsr[31:16],
                (lfsr[6:5] == 2'd0) ? 16'h0000 : lfsr[15:0], "R9");
        end

        idle();
        @(negedge clk);
        // R11: strobe drops and outputs hold while idle
        hold_hi = hi_out;
        repeat (3) @(negedge clk);
        check(!done, "R11", "done low when idle", {39'h0, done}, 40'd0);
        check(hi_out == hold_hi, "R11", "hi_out held", {24'h0, hi_out}, {24'h0, hold_hi});
        check(sb.size() == 0, "R11", "all results seen", 40'(sb.size()), 40'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule